// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Sequencer

This block sequences bulk transfers between a byte-wide volatile array and a nonvolatile shadow array of the same depth. A store copies the volatile contents into the shadow. A recall copies the shadow back into the volatile array. Both arrays sit outside the block. The sequencer drives their address, write-enable and write-data pins and takes their read data back combinationally. A command detector upstream raises one-cycle store and recall requests. Two digital supply flags tell the sequencer whether the supply is above the switch threshold and above the reset threshold.

Every transfer has two phases. The first phase wipes the destination: the shadow is erased to a fixed value on a store, and the volatile array is cleared to another fixed value on a recall. The second phase copies one byte per clock. The sequencer then holds until the operation's duration, a cycle-count parameter, has run out. External access stays locked out for the whole span. When the supply falls below the reset threshold, the sequencer latches a recall. That recall runs as soon as the supply is back above the switch threshold, and the power loss also abandons any transfer in flight. Stores are refused while the supply is below the switch threshold.

Top module: `nvshadow_seq`

## Requirements
- R1: After reset, busy, io_disable, sram_we and nv_we are 0, and both address outputs and both write-data outputs are 0.
- R2: An accepted store (store_req sampled high while idle, supply above both thresholds, no recall pending) starts the next cycle. It writes ERASE_VAL to shadow addresses 0 to DEPTH-1, one per cycle in ascending order. It then writes sram_rdata of address k to shadow address k for k = 0 to DEPTH-1, one per cycle. sram_we stays 0 throughout.
- R3: An accepted software recall (recall_req sampled high while idle, supply above the reset threshold, no recall pending, no store_req in the same cycle) writes CLEAR_VAL to volatile addresses 0 to DEPTH-1. It then writes nv_rdata of address k to volatile address k, one per cycle. nv_we stays 0, so the shadow keeps its contents.
- R4: busy stays high for exactly max(C, 2*DEPTH) consecutive cycles, where C is STORE_CYC, RECALL_CYC or PWRUP_CYC depending on the operation. During the wipe and copy phases both address outputs carry the step index, and they read 0 while holding and while idle. With no recall pending, busy and io_disable fall in the same cycle.
- R5: store_req is ignored while vcc_above_switch is 0.
- R6: store_req and recall_req that arrive while busy is high are dropped and have no later effect.
- R7: A cycle in which vcc_above_reset is sampled 0 latches a pending recall. io_disable is 1 while a recall is pending.
- R8: A pending recall starts in the cycle after vcc_above_switch is sampled 1, and it clears the pending flag. It runs as a recall lasting max(PWRUP_CYC, 2*DEPTH) cycles and wins over any store_req or recall_req in the same cycle. Software requests are dropped while it is pending.
- R9: A supply dip below the switch threshold, with vcc_above_reset staying 1, starts no recall on recovery.
- R10: If vcc_above_reset is sampled 0 during a transfer, busy is 0 the next cycle and no further array writes occur.
- R11: When store_req and recall_req are sampled high together and a store is allowed, the store is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| store_req | input | 1 | One-cycle store request |
| recall_req | input | 1 | One-cycle software recall request |
| vcc_above_switch | input | 1 | Supply is above the switch threshold |
| vcc_above_reset | input | 1 | Supply is above the reset threshold |
| busy | output | 1 | A transfer is in progress |
| io_disable | output | 1 | External array access must be blocked |
| sram_addr | output | AW | Volatile array address |
| sram_we | output | 1 | Volatile array write enable |
| sram_wdata | output | DW | Volatile array write data |
| sram_rdata | input | DW | Volatile array read data (combinational) |
| nv_addr | output | AW | Shadow array address |
| nv_we | output | 1 | Shadow array write enable |
| nv_wdata | output | DW | Shadow array write data |
| nv_rdata | input | DW | Shadow array read data (combinational) |

## Verification
Some properties are checked by assertions on every cycle:
- the copy index steps by one;
- the span counter never passes its limit;
- the operation kind stays fixed while busy;
- the two write enables never assert together;
- a power loss latches the pending flag and ends a transfer in the next cycle;
- the pending flag clears only when a power-up recall is launched;
- a store never begins after a cycle with the supply below the switch threshold.

Other behaviour shows only in the bench scenarios, where a behavioural model predicts every output on every cycle: the actual array contents after a store or recall, the exact busy span for each kind of operation, which request wins when several arrive together, dropped requests, and a supply dip that must cause no recall.

// File: rtl/nvshadow_pkg.sv
package nvshadow_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLEAR = 2'd1,
    PH_COPY  = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_SWRCL  = 2'd2,
    OP_PWRRCL = 2'd3
  } op_e;

  // Busy span of one transfer: the requested duration, but never less than
  // the wipe pass plus the copy pass.
  function automatic int busy_span(input int req_cyc, input int depth);
    return (req_cyc > 2 * depth) ? req_cyc : 2 * depth;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic is_recall(input op_e op);
    return (op == OP_SWRCL) || (op == OP_PWRRCL);
  endfunction

endpackage

// File: rtl/nvs_start_arb.sv
module nvs_start_arb
  import nvshadow_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic store_req,
  input  logic recall_req,
  input  logic vcc_above_switch,
  input  logic vcc_above_reset,
  output op_e  start_op,
  output logic start,
  output logic pend_pwr
);

  // Launch choice: a pending power-up recall first, then a store, then a
  // software recall. Nothing launches while busy or below the reset level.
  always_comb begin
    start_op = OP_NONE;
    if (idle && vcc_above_reset) begin
      if (pend_pwr) begin
        if (vcc_above_switch) start_op = OP_PWRRCL;
      end else if (store_req && vcc_above_switch) begin
        start_op = OP_STORE;
      end else if (recall_req) begin
        start_op = OP_SWRCL;
      end
    end
  end

  assign start = (start_op != OP_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n)                     pend_pwr <= 1'b0;
    else if (!vcc_above_reset)      pend_pwr <= 1'b1;
    else if (start_op == OP_PWRRCL) pend_pwr <= 1'b0;
  end

  // R7
  pend_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_above_reset |=> pend_pwr);

  // R8
  pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_pwr) |-> $past(start && vcc_above_switch && vcc_above_reset));

endmodule

// File: rtl/nvs_phase_ctrl.sv
module nvs_phase_ctrl
  import nvshadow_pkg::*;
#(
  parameter int DEPTH       = 2048,
  parameter int AW          = 11,
  parameter int CW          = 22,
  parameter int STORE_SPAN  = 4096,
  parameter int RECALL_SPAN = 4096,
  parameter int PWRUP_SPAN  = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  op_e           start_op,
  input  logic          abort,
  output phase_e        phase,
  output op_e           op,
  output logic [AW-1:0] idx,
  output logic          span_end
);

  localparam logic [AW-1:0] IDX_LAST = AW'(DEPTH - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] span_last;
  logic          idx_last;

  always_comb begin
    case (op)
      OP_STORE:  span_last = CW'(STORE_SPAN - 1);
      OP_SWRCL:  span_last = CW'(RECALL_SPAN - 1);
      OP_PWRRCL: span_last = CW'(PWRUP_SPAN - 1);
      default:   span_last = '0;
    endcase
  end

  assign idx_last = (idx == IDX_LAST);
  assign span_end = (phase != PH_IDLE) && (cnt == span_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      op    <= OP_NONE;
      idx   <= '0;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase <= PH_CLEAR;
        op    <= start_op;
        idx   <= '0;
        cnt   <= '0;
      end
    end else if (abort || span_end) begin
      phase <= PH_IDLE;
      op    <= OP_NONE;
      idx   <= '0;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      case (phase)
        PH_CLEAR: begin
          if (idx_last) begin
            phase <= PH_COPY;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_COPY: begin
          if (idx_last) phase <= PH_HOLD;
          else          idx   <= idx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R2
  copy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COPY) && $past(phase == PH_COPY) |-> idx == AW'($past(idx) + 1'b1));

  // R4
  span_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> cnt <= span_last);

  // R10
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) && abort |=> phase == PH_IDLE);

endmodule

// File: rtl/nvs_port_drive.sv
module nvs_port_drive
  import nvshadow_pkg::*;
#(
  parameter int            AW        = 11,
  parameter int            DW        = 8,
  parameter logic [DW-1:0] ERASE_VAL = '1,
  parameter logic [DW-1:0] CLEAR_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  op_e           op,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] sram_rdata,
  input  logic [DW-1:0] nv_rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_we,
  output logic [DW-1:0] sram_wdata,
  output logic [AW-1:0] nv_addr,
  output logic          nv_we,
  output logic [DW-1:0] nv_wdata
);

  logic stepping;
  logic wiping;

  assign stepping = (phase == PH_CLEAR) || (phase == PH_COPY);
  assign wiping   = (phase == PH_CLEAR);

  always_comb begin
    sram_addr  = stepping ? idx : '0;
    nv_addr    = stepping ? idx : '0;
    sram_we    = 1'b0;
    nv_we      = 1'b0;
    sram_wdata = '0;
    nv_wdata   = '0;
    if (stepping) begin
      if (op == OP_STORE) begin
        nv_we    = 1'b1;
        nv_wdata = wiping ? ERASE_VAL : sram_rdata;
      end else if (is_recall(op)) begin
        sram_we    = 1'b1;
        sram_wdata = wiping ? CLEAR_VAL : nv_rdata;
      end
    end
  end

  // R3
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sram_we, nv_we}));

endmodule

// File: rtl/nvshadow_seq.sv
module nvshadow_seq
  import nvshadow_pkg::*;
#(
  parameter int DEPTH      = 2048,
  parameter int DW         = 8,
  parameter int STORE_CYC  = 2_500_000,
  parameter int RECALL_CYC = 5_000,
  parameter int PWRUP_CYC  = 137_500,
  parameter logic [DW-1:0] ERASE_VAL = '1,
  parameter logic [DW-1:0] CLEAR_VAL = '0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store_req,
  input  logic          recall_req,
  input  logic          vcc_above_switch,
  input  logic          vcc_above_reset,
  output logic          busy,
  output logic          io_disable,
  output logic [AW-1:0] sram_addr,
  output logic          sram_we,
  output logic [DW-1:0] sram_wdata,
  input  logic [DW-1:0] sram_rdata,
  output logic [AW-1:0] nv_addr,
  output logic          nv_we,
  output logic [DW-1:0] nv_wdata,
  input  logic [DW-1:0] nv_rdata
);

  localparam int STORE_SPAN  = busy_span(STORE_CYC, DEPTH);
  localparam int RECALL_SPAN = busy_span(RECALL_CYC, DEPTH);
  localparam int PWRUP_SPAN  = busy_span(PWRUP_CYC, DEPTH);
  localparam int MAX_SPAN    = max3(STORE_SPAN, RECALL_SPAN, PWRUP_SPAN);
  localparam int CW          = $clog2(MAX_SPAN + 1);

  phase_e        phase;
  op_e           op;
  op_e           start_op;
  logic          start;
  logic          pend_pwr;
  logic          abort;
  logic          span_end;
  logic [AW-1:0] idx;

  assign busy       = (phase != PH_IDLE);
  assign abort      = busy && !vcc_above_reset;
  assign io_disable = busy || pend_pwr;

  nvs_start_arb u_arb (
    .clk              (clk),
    .rst_n            (rst_n),
    .idle             (!busy),
    .store_req        (store_req),
    .recall_req       (recall_req),
    .vcc_above_switch (vcc_above_switch),
    .vcc_above_reset  (vcc_above_reset),
    .start_op         (start_op),
    .start            (start),
    .pend_pwr         (pend_pwr)
  );

  nvs_phase_ctrl #(
    .DEPTH       (DEPTH),
    .AW          (AW),
    .CW          (CW),
    .STORE_SPAN  (STORE_SPAN),
    .RECALL_SPAN (RECALL_SPAN),
    .PWRUP_SPAN  (PWRUP_SPAN)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_op (start_op),
    .abort    (abort),
    .phase    (phase),
    .op       (op),
    .idx      (idx),
    .span_end (span_end)
  );

  nvs_port_drive #(
    .AW        (AW),
    .DW        (DW),
    .ERASE_VAL (ERASE_VAL),
    .CLEAR_VAL (CLEAR_VAL)
  ) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .op         (op),
    .idx        (idx),
    .sram_rdata (sram_rdata),
    .nv_rdata   (nv_rdata),
    .sram_addr  (sram_addr),
    .sram_we    (sram_we),
    .sram_wdata (sram_wdata),
    .nv_addr    (nv_addr),
    .nv_we      (nv_we),
    .nv_wdata   (nv_wdata)
  );

  // R5
  store_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && (op == OP_STORE) |-> $past(vcc_above_switch));

  // R6
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(span_end) |-> $stable(op));

  // R4
  span_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    span_end && vcc_above_reset |=> !busy);

endmodule

// File: tb/tb_nvshadow_seq.sv
module tb_nvshadow_seq;

  localparam int D  = 16;
  localparam int AW = 4;
  localparam int SC = 50;
  localparam int RC = 20;
  localparam int PC = 40;
  localparam logic [7:0] EV = 8'hFF;
  localparam logic [7:0] CV = 8'h00;

  logic clk = 0, rst_n = 0;
  logic store_req = 0, recall_req = 0, vs = 1, vr = 1;
  logic busy, io_disable, sram_we, nv_we;
  logic [AW-1:0] sram_addr, nv_addr;
  logic [7:0] sram_wdata, nv_wdata, sram_rdata, nv_rdata;
  logic host_we = 0;
  logic [AW-1:0] host_addr = 0;
  logic [7:0] host_data = 0;
  logic [7:0] sram_m [0:D-1];
  logic [7:0] nv_m   [0:D-1];

  int total = 0, bad = 0;
  bit fin = 0;

  always #2 clk = ~clk;

  nvshadow_seq #(
    .DEPTH(D), .DW(8), .STORE_CYC(SC), .RECALL_CYC(RC), .PWRUP_CYC(PC),
    .ERASE_VAL(EV), .CLEAR_VAL(CV)
  ) dut (
    .clk(clk), .rst_n(rst_n), .store_req(store_req), .recall_req(recall_req),
    .vcc_above_switch(vs), .vcc_above_reset(vr), .busy(busy), .io_disable(io_disable),
    .sram_addr(sram_addr), .sram_we(sram_we), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .nv_addr(nv_addr), .nv_we(nv_we), .nv_wdata(nv_wdata), .nv_rdata(nv_rdata)
  );

  // behavioural arrays with asynchronous read
  assign sram_rdata = sram_m[sram_addr];
  assign nv_rdata   = nv_m[nv_addr];
  always @(posedge clk) begin
    if (sram_we)      sram_m[sram_addr] <= sram_wdata;
    else if (host_we) sram_m[host_addr] <= host_data;
    if (nv_we) nv_m[nv_addr] <= nv_wdata;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 store, 2 software recall, 3 power-up recall
  int m_op = 0, m_pos = 0, m_len = 0;
  bit m_pend = 0;

  function automatic int span_of(input int c);
    if (c < 2 * D) return 2 * D;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_op = 0; m_pos = 0; m_pend = 0;
    end else begin
      if (m_op != 0) begin
        if (!vr) m_op = 0;
        else begin
          m_pos++;
          if (m_pos == m_len) m_op = 0;
        end
      end else if (vr) begin
        if (m_pend) begin
          if (vs) begin m_op = 3; m_len = span_of(PC); m_pos = 0; m_pend = 0; end
        end else if (store_req && vs) begin
          m_op = 1; m_len = span_of(SC); m_pos = 0;
        end else if (recall_req) begin
          m_op = 2; m_len = span_of(RC); m_pos = 0;
        end
      end
      if (!vr) m_pend = 1;
    end
  end

  int e_sa, e_na, e_sd, e_nd, k;
  bit e_sw, e_nw, e_busy, e_io;
  string tg;

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      e_busy = (m_op != 0);
      e_io   = e_busy || m_pend;
      e_sw = 0; e_nw = 0; e_sa = 0; e_na = 0; e_sd = 0; e_nd = 0;
      tg = (m_op == 1) ? "R2" : (m_op == 2) ? "R3" : (m_op == 3) ? "R8" : "R1";
      if (m_op != 0 && m_pos < 2 * D) begin
        k = (m_pos < D) ? m_pos : m_pos - D;
        e_sa = k; e_na = k;
        if (m_op == 1) begin e_nw = 1; e_nd = (m_pos < D) ? int'(EV) : int'(sram_m[k]); end
        else begin e_sw = 1; e_sd = (m_pos < D) ? int'(CV) : int'(nv_m[k]); end
      end
      chk(busy == e_busy, "R4", "busy", busy, e_busy);
      chk(io_disable == e_io, "R7", "io_disable", io_disable, e_io);
      chk(sram_we == e_sw, tg, "sram_we", sram_we, e_sw);
      chk(nv_we == e_nw, tg, "nv_we", nv_we, e_nw);
      chk(int'(sram_addr) == e_sa, tg, "sram_addr", sram_addr, e_sa);
      chk(int'(nv_addr) == e_na, tg, "nv_addr", nv_addr, e_na);
      chk(int'(sram_wdata) == e_sd, tg, "sram_wdata", sram_wdata, e_sd);
      chk(int'(nv_wdata) == e_nd, tg, "nv_wdata", nv_wdata, e_nd);
    end
  end

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + 5) & 255);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic host_fill(input int seed);
    for (int i = 0; i < D; i++) begin
      host_we = 1; host_addr = AW'(i); host_data = pat(i, seed);
      tick();
    end
    host_we = 0;
  endtask

  task automatic pulse(input bit s, input bit r);
    store_req = s; recall_req = r;
    tick();
    store_req = 0; recall_req = 0;
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int g = 0; g < 1000; g++) begin
      @(negedge clk);
      if (busy) n++;
      else break;
    end
  endtask

  task automatic quiet(input int cyc, input string tag);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      chk(!busy, tag, "busy stays low", busy, 0);
      tick();
    end
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !io_disable, "R1", "busy|io after reset", busy | io_disable, 0);
    chk(!sram_we && !nv_we, "R1", "write enables after reset", sram_we | nv_we, 0);
    tick();

    // R2 store, R4 span
    host_fill(1);
    pulse(1, 0);
    measure(n);
    chk(n == span_of(SC), "R4", "store span", n, span_of(SC));
    chk(!io_disable, "R4", "io re-enabled with busy", io_disable, 0);
    for (int i = 0; i < D; i++) chk(nv_m[i] == pat(i, 1), "R2", "shadow after store", nv_m[i], pat(i, 1));

    // R3 software recall, span floored at two passes
    tick();
    host_fill(2);
    pulse(0, 1);
    measure(n);
    chk(n == span_of(RC), "R4", "recall span", n, span_of(RC));
    for (int i = 0; i < D; i++) chk(sram_m[i] == pat(i, 1), "R3", "sram after recall", sram_m[i], pat(i, 1));
    for (int i = 0; i < D; i++) chk(nv_m[i] == pat(i, 1), "R3", "shadow kept", nv_m[i], pat(i, 1));

    // R5 store refused below switch level
    tick();
    vs = 0; tick();
    pulse(1, 0);
    quiet(4, "R5");
    vs = 1; tick();

    // R6 requests during busy dropped
    host_fill(3);
    pulse(1, 0);
    repeat (3) tick();
    pulse(1, 1);
    measure(n);
    quiet(6, "R6");
    for (int i = 0; i < D; i++) chk(nv_m[i] == pat(i, 3), "R6", "shadow after store", nv_m[i], pat(i, 3));

    // R11 store wins over recall
    host_fill(4);
    pulse(1, 1);
    measure(n);
    chk(n == span_of(SC), "R11", "span shows store", n, span_of(SC));
    for (int i = 0; i < D; i++) chk(nv_m[i] == pat(i, 4), "R11", "shadow after store", nv_m[i], pat(i, 4));

    // R9 dip above reset level
    tick();
    vs = 0; repeat (5) tick();
    vs = 1; tick();
    quiet(6, "R9");
    @(negedge clk);
    chk(!io_disable, "R9", "io after dip", io_disable, 0);

    // R7 power loss latches recall
    tick();
    vr = 0; vs = 0; repeat (2) tick();
    @(negedge clk);
    chk(io_disable && !busy, "R7", "io locked idle", {io_disable, busy}, 2);
    tick();
    host_fill(9);
    vr = 1; repeat (2) tick();
    pulse(1, 0);
    pulse(0, 1);
    quiet(3, "R8");
    @(negedge clk);
    chk(io_disable, "R7", "still pending", io_disable, 1);
    tick();
    // R8 power-up recall beats a same-cycle store
    vs = 1; store_req = 1;
    tick();
    store_req = 0;
    measure(n);
    chk(n == span_of(PC), "R8", "power-up span", n, span_of(PC));
    chk(!io_disable, "R8", "io after power-up recall", io_disable, 0);
    for (int i = 0; i < D; i++) chk(sram_m[i] == pat(i, 4), "R8", "sram restored", sram_m[i], pat(i, 4));

    // R10 power loss aborts a store
    tick();
    host_fill(5);
    pulse(1, 0);
    repeat (5) tick();
    vr = 0; vs = 0;
    @(negedge clk);
    chk(busy, "R10", "busy before sampled loss", busy, 1);
    tick();
    @(negedge clk);
    chk(!busy && io_disable, "R10", "abort next cycle", {busy, io_disable}, 1);
    chk(!sram_we && !nv_we, "R10", "no writes after abort", {sram_we, nv_we}, 0);
    tick();
    vr = 1; vs = 1;
    tick();
    measure(n);
    chk(n == span_of(PC), "R10", "recovery recall span", n, span_of(PC));
    for (int i = 0; i < D; i++) chk(sram_m[i] == nv_m[i], "R10", "sram equals shadow", sram_m[i], nv_m[i]);
    tick();
    finish_run();
  end

endmodule